// File: doc/BRIEF.md
# Synchronous Buck Gate Timing Controller

This block sequences the two power-switch gates of a synchronous buck stage from a fast system clock. Each switching cycle runs through four phases: high-side conduction, a dead interval, low-side conduction and a second dead interval. During both dead intervals both gate outputs stay low, and the freewheeling current flows through the switch's body diode or an external Schottky diode. Analog comparators outside the block supply two flags. One is high while the output sits below its regulation threshold. The other is high once the inductor current has reversed.

There are two operating modes. In fixed-frequency mode a new cycle begins every `period_cfg` clocks. The high-side on time is the duty fraction of that period, and the low side takes whatever remains after both dead intervals. In light-load skip mode a cycle begins only when the output has dropped below threshold. The high side then conducts for a fixed minimum on time. The low side conducts until the inductor current reverses, so the cycle rate follows the load. In both modes the low side is opened as soon as the current reverses. Period, duty, dead time and mode are all captured when a cycle starts.

Top module: `buck_gate_ctrl`

## Requirements
- R1: `hs_gate` and `ls_gate` are never high in the same cycle.
- R2: In fixed-frequency mode the high side is on for floor(`duty_cfg` × `period_cfg` / 2^DUTY_W) cycles. This value is clamped to `period_cfg` − 2·D, where D is the effective dead time.
- R3: In fixed-frequency mode the low side is on for `period_cfg` − 2·D − (high-side time), and cycles start exactly `period_cfg` clocks apart.
- R4: Both dead intervals last D = max(`dead_cfg`, 1) clocks, with both gates low. A setting of 0 behaves as 1.
- R5: In skip mode a cycle starts only on a clock edge where `below_thr` is high while the block is idle. With `below_thr` low, no new cycle starts.
- R6: A skip cycle holds the high side on for exactly 8 clocks. The low side follows after D clocks and stays on until reverse current is seen or `period_cfg` clocks have passed.
- R7: When `zero_cross` is high at an edge while the low side is on, the low side is off from the next cycle. In fixed-frequency mode the next cycle still starts `period_cfg` clocks after the previous one.
- R8: `zero_cross` has no effect outside the low-side phase. The high-side on time is unchanged while it is held high.
- R9: A synchronous active-high `rst` forces both gates low from the next edge. The first cycle begins at the first edge after release.
- R10: In skip mode, if `below_thr` is still high when the trailing dead interval ends, the next cycle starts with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| skip_mode | input | 1 | 0 = fixed-frequency, 1 = light-load skip |
| period_cfg | input | PERIOD_W | Switching period in clocks; also the skip low-side limit |
| duty_cfg | input | DUTY_W | Duty fraction, in units of 1/2^DUTY_W |
| dead_cfg | input | DT_W | Dead time in clocks (0 treated as 1) |
| below_thr | input | 1 | High while the output is below the regulation threshold |
| zero_cross | input | 1 | High when the inductor current has reversed |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| cycle_strobe | output | 1 | One-clock pulse at the start of each switching cycle |

## Verification
The assertions assume that `period_cfg` exceeds twice the dead time. They also assume that the comparator flags are synchronous to `clk`, so `zero_cross` is a clean sampled level when the low side is on. The stimulus drives every input at the falling clock edge and uses periods of 40 clocks with dead times of at most 5. Each configuration change is followed by one discarded cycle, because settings are captured only at cycle start. The skip-mode demand flag is raised either as a single-clock pulse or as a steady level, so that single and back-to-back cycles both appear.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_HIGH  = 3'd1,
    PH_DEAD1 = 3'd2,
    PH_LOW   = 3'd3,
    PH_DEAD2 = 3'd4
  } phase_e;

  // Effective dead time: at least one clock so the gates never swap on one edge.
  function automatic int unsigned dead_eff(input int unsigned cfg);
    return (cfg == 0) ? 1 : cfg;
  endfunction

  // Room left for conduction once both dead intervals are removed.
  function automatic int unsigned conduct_room(input int unsigned period,
                                               input int unsigned dt);
    return (period > 2 * dt) ? (period - 2 * dt) : 0;
  endfunction

  // Fixed-frequency high-side length: duty fraction of period, clamped to room.
  function automatic int unsigned pwm_high_len(input int unsigned duty,
                                               input int unsigned period,
                                               input int unsigned dt,
                                               input int unsigned duty_w);
    int unsigned raw;
    int unsigned room;
    raw  = (duty * period) >> duty_w;
    room = conduct_room(period, dt);
    return (raw < room) ? raw : room;
  endfunction

  // Fixed-frequency low-side length: the remainder of the room.
  function automatic int unsigned pwm_low_len(input int unsigned period,
                                              input int unsigned dt,
                                              input int unsigned high);
    return conduct_room(period, dt) - high;
  endfunction

  // Skip-mode low-side limit when no reversal is seen.
  function automatic int unsigned skip_low_len(input int unsigned period);
    return (period == 0) ? 1 : period;
  endfunction

  // True when the elapsed count marks the final clock of a period.
  function automatic logic period_reached(input int unsigned elapsed,
                                          input int unsigned period);
    return (elapsed + 1) >= period;
  endfunction

endpackage

// File: rtl/buck_cycle_timer.sv
module buck_cycle_timer
  import buck_gate_pkg::*;
#(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                skip_mode,
  input  logic                below_thr,
  input  logic [PERIOD_W-1:0] period_cfg,
  input  logic                in_idle,
  input  logic                last_end,
  output logic                start_now,
  output logic                cycle_strobe
);

  logic [PERIOD_W-1:0] elapsed_q;
  logic                start_ok;
  logic                strobe_q;

  always_comb begin
    if (skip_mode) begin
      start_ok = below_thr;
    end else begin
      start_ok = period_reached(32'(elapsed_q), 32'(period_cfg));
    end
  end

  assign start_now = start_ok && (in_idle || last_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= '1;
    end else if (start_now) begin
      elapsed_q <= '0;
    end else if (elapsed_q != '1) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= start_now;
    end
  end

  assign cycle_strobe = strobe_q;

endmodule

// File: rtl/buck_phase_fsm.sv
module buck_phase_fsm
  import buck_gate_pkg::*;
#(
  parameter int PERIOD_W = 10,
  parameter int DUTY_W   = 8,
  parameter int DT_W     = 6,
  parameter int MIN_ON   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_now,
  input  logic                skip_mode,
  input  logic [PERIOD_W-1:0] period_cfg,
  input  logic [DUTY_W-1:0]   duty_cfg,
  input  logic [DT_W-1:0]     dead_cfg,
  input  logic                zero_cross,
  output phase_e              phase_q,
  output phase_e              phase_d,
  output logic                in_idle,
  output logic                last_end,
  output logic                low_cut
);

  localparam int CNT_W = (PERIOD_W > DT_W) ? PERIOD_W : DT_W;

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [DT_W-1:0]     dt_q;
  logic [PERIOD_W-1:0] low_len_q;
  logic                load_cfg;

  int unsigned dt_c;
  int unsigned high_c;
  int unsigned low_c;

  always_comb begin
    dt_c = dead_eff(32'(dead_cfg));
    if (skip_mode) begin
      high_c = MIN_ON;
      low_c  = skip_low_len(32'(period_cfg));
    end else begin
      high_c = pwm_high_len(32'(duty_cfg), 32'(period_cfg), dt_c, DUTY_W);
      low_c  = pwm_low_len(32'(period_cfg), dt_c, high_c);
    end
  end

  assign in_idle  = (phase_q == PH_IDLE);
  assign last_end = (phase_q == PH_DEAD2) && (cnt_q == '0);
  assign low_cut  = (phase_q == PH_LOW) && zero_cross;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = (cnt_q != '0) ? (cnt_q - 1'b1) : cnt_q;
    load_cfg = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_now) begin
          load_cfg = 1'b1;
          if (high_c != 0) begin
            phase_d = PH_HIGH;
            cnt_d   = CNT_W'(high_c - 1);
          end else begin
            phase_d = PH_DEAD1;
            cnt_d   = CNT_W'(dt_c - 1);
          end
        end
      end
      PH_HIGH: begin
        if (cnt_q == '0) begin
          phase_d = PH_DEAD1;
          cnt_d   = CNT_W'(dt_q) - 1'b1;
        end
      end
      PH_DEAD1: begin
        if (cnt_q == '0) begin
          if (low_len_q != '0) begin
            phase_d = PH_LOW;
            cnt_d   = CNT_W'(low_len_q) - 1'b1;
          end else begin
            phase_d = PH_DEAD2;
            cnt_d   = CNT_W'(dt_q) - 1'b1;
          end
        end
      end
      PH_LOW: begin
        if (low_cut || (cnt_q == '0)) begin
          phase_d = PH_DEAD2;
          cnt_d   = CNT_W'(dt_q) - 1'b1;
        end
      end
      PH_DEAD2: begin
        if (cnt_q == '0) begin
          if (start_now) begin
            load_cfg = 1'b1;
            if (high_c != 0) begin
              phase_d = PH_HIGH;
              cnt_d   = CNT_W'(high_c - 1);
            end else begin
              phase_d = PH_DEAD1;
              cnt_d   = CNT_W'(dt_c - 1);
            end
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      dt_q      <= DT_W'(1);
      low_len_q <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (load_cfg) begin
        dt_q      <= DT_W'(dt_c);
        low_len_q <= PERIOD_W'(low_c);
      end
    end
  end

endmodule

// File: rtl/buck_gate_out.sv
module buck_gate_out
  import buck_gate_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase_d,
  output logic   hs_gate,
  output logic   ls_gate
);

  logic hs_q;
  logic ls_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= (phase_d == PH_HIGH);
      ls_q <= (phase_d == PH_LOW);
    end
  end

  assign hs_gate = hs_q;
  assign ls_gate = ls_q;

endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl
  import buck_gate_pkg::*;
#(
  parameter int PERIOD_W = 10,
  parameter int DUTY_W   = 8,
  parameter int DT_W     = 6,
  parameter int MIN_ON   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                skip_mode,
  input  logic [PERIOD_W-1:0] period_cfg,
  input  logic [DUTY_W-1:0]   duty_cfg,
  input  logic [DT_W-1:0]     dead_cfg,
  input  logic                below_thr,
  input  logic                zero_cross,
  output logic                hs_gate,
  output logic                ls_gate,
  output logic                cycle_strobe
);

  phase_e phase_q;
  phase_e phase_d;
  logic   start_now;
  logic   in_idle;
  logic   last_end;
  logic   low_cut;

  buck_cycle_timer #(
    .PERIOD_W(PERIOD_W)
  ) timer_i (
    .clk         (clk),
    .rst         (rst),
    .skip_mode   (skip_mode),
    .below_thr   (below_thr),
    .period_cfg  (period_cfg),
    .in_idle     (in_idle),
    .last_end    (last_end),
    .start_now   (start_now),
    .cycle_strobe(cycle_strobe)
  );

  buck_phase_fsm #(
    .PERIOD_W(PERIOD_W),
    .DUTY_W  (DUTY_W),
    .DT_W    (DT_W),
    .MIN_ON  (MIN_ON)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .start_now (start_now),
    .skip_mode (skip_mode),
    .period_cfg(period_cfg),
    .duty_cfg  (duty_cfg),
    .dead_cfg  (dead_cfg),
    .zero_cross(zero_cross),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .in_idle   (in_idle),
    .last_end  (last_end),
    .low_cut   (low_cut)
  );

  buck_gate_out out_i (
    .clk    (clk),
    .rst    (rst),
    .phase_d(phase_d),
    .hs_gate(hs_gate),
    .ls_gate(ls_gate)
  );

endmodule

// File: rtl/buck_gate_chk.sv
module buck_gate_chk (
  input logic clk,
  input logic rst,
  input logic skip_mode,
  input logic below_thr,
  input logic zero_cross,
  input logic low_cut,
  input logic hs_gate,
  input logic ls_gate
);

  // R1
  gates_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));

  // R4
  hs_fall_dead_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_gate) |-> !ls_gate);

  // R4
  ls_rise_dead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> $past(!hs_gate));

  // R4
  ls_fall_dead_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ls_gate) |-> !hs_gate);

  // R5
  skip_demand_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hs_gate) && $past(skip_mode)) |-> $past(below_thr));

  // R7
  reversal_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (ls_gate && zero_cross) |=> !ls_gate);

  // R7
  cut_event_chk: assert property (@(posedge clk) disable iff (rst)
    low_cut |=> !ls_gate);

  // R9
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!hs_gate && !ls_gate));

endmodule

bind buck_gate_ctrl buck_gate_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .skip_mode (skip_mode),
  .below_thr (below_thr),
  .zero_cross(zero_cross),
  .low_cut   (low_cut),
  .hs_gate   (hs_gate),
  .ls_gate   (ls_gate)
);

// File: tb/buck_gate_ctrl_tb.sv
`timescale 1ns/1ps
module buck_gate_ctrl_tb_top;

  localparam int PERIOD_W = 10;
  localparam int DUTY_W   = 8;
  localparam int DT_W     = 6;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                skip_mode = 1'b0;
  logic [PERIOD_W-1:0] period_cfg = 10'd40;
  logic [DUTY_W-1:0]   duty_cfg = 8'd128;
  logic [DT_W-1:0]     dead_cfg = 6'd3;
  logic                below_thr = 1'b0;
  logic                zero_cross = 1'b0;
  logic                hs_gate;
  logic                ls_gate;
  logic                cycle_strobe;

  int checks = 0;
  int errors = 0;
  int overlap_cnt = 0;

  always #2 clk = ~clk;

  buck_gate_ctrl #(
    .PERIOD_W(PERIOD_W),
    .DUTY_W  (DUTY_W),
    .DT_W    (DT_W),
    .MIN_ON  (8)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .skip_mode   (skip_mode),
    .period_cfg  (period_cfg),
    .duty_cfg    (duty_cfg),
    .dead_cfg    (dead_cfg),
    .below_thr   (below_thr),
    .zero_cross  (zero_cross),
    .hs_gate     (hs_gate),
    .ls_gate     (ls_gate),
    .cycle_strobe(cycle_strobe)
  );

  always @(negedge clk) begin
    if (!rst && hs_gate && ls_gate) overlap_cnt++;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Measures one cycle from a high-side rise: high, gap, low, gap.
  task automatic measure(output int h, output int g1, output int l, output int g2);
    int guard;
    guard = 0; h = 0; g1 = 0; l = 0; g2 = 0;
    while (hs_gate !== 1'b0 && guard < 4000) begin step(); guard++; end
    while (hs_gate !== 1'b1 && guard < 4000) begin step(); guard++; end
    while (hs_gate === 1'b1 && guard < 4000) begin h++; step(); guard++; end
    while (hs_gate === 1'b0 && ls_gate === 1'b0 && guard < 4000) begin g1++; step(); guard++; end
    while (ls_gate === 1'b1 && guard < 4000) begin l++; step(); guard++; end
    while (hs_gate === 1'b0 && ls_gate === 1'b0 && guard < 4000) begin g2++; step(); guard++; end
    if (guard >= 4000) check("measure timeout", guard, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    check("R9 reset hs", int'(hs_gate), 0);
    check("R9 reset ls", int'(ls_gate), 0);
    rst = 1'b0;
    step();
    check("R9 first cycle after release", int'(hs_gate), 1);
  endtask

  task automatic t_pwm(input int duty, input int dead, input int eh, input int eg1,
                       input int el, input int eg2, input string tag);
    int h, g1, l, g2;
    duty_cfg = DUTY_W'(duty);
    dead_cfg = DT_W'(dead);
    measure(h, g1, l, g2);
    measure(h, g1, l, g2);
    check({tag, " R2 high"}, h, eh);
    check({tag, " R4 gap1"}, g1, eg1);
    check({tag, " R3 low"}, l, el);
    check({tag, " R3 period"}, h + g1 + l + g2, 40);
    if (el != 0) check({tag, " R4 gap2"}, g2, eg2);
  endtask

  task automatic t_pwm_reversal();
    int h, g1, l, g2;
    duty_cfg = 8'd128;
    dead_cfg = 6'd3;
    zero_cross = 1'b1;
    measure(h, g1, l, g2);
    measure(h, g1, l, g2);
    check("R8 high unchanged under reversal", h, 20);
    check("R7 low cut after one clock", l, 1);
    check("R7 period kept", h + g1 + l + g2, 40);
    check("R7 trailing gap padded", g2, 16);
    zero_cross = 1'b0;
  endtask

  task automatic t_skip_idle_and_single();
    int rises, highs;
    logic prev;
    skip_mode = 1'b1;
    below_thr = 1'b0;
    zero_cross = 1'b1;
    dead_cfg = 6'd2;
    repeat (100) step();
    rises = 0;
    prev = hs_gate;
    for (int i = 0; i < 200; i++) begin
      step();
      if (hs_gate && !prev) rises++;
      prev = hs_gate;
    end
    check("R5 no cycle without demand", rises, 0);
    below_thr = 1'b1;
    step();
    below_thr = 1'b0;
    rises = 0;
    highs = 0;
    prev = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (hs_gate && !prev) rises++;
      if (hs_gate) highs++;
      prev = hs_gate;
      step();
    end
    check("R5 one cycle per demand pulse", rises, 1);
    check("R6 minimum on time", highs, 8);
  endtask

  task automatic t_skip_cont();
    int h, g1, l, g2;
    below_thr = 1'b1;
    zero_cross = 1'b1;
    measure(h, g1, l, g2);
    measure(h, g1, l, g2);
    check("R6 skip high", h, 8);
    check("R4 skip gap1", g1, 2);
    check("R6 skip low cut", l, 1);
    check("R10 back-to-back gap", g2, 2);
  endtask

  task automatic t_skip_cap();
    int h, g1, l, g2;
    zero_cross = 1'b0;
    measure(h, g1, l, g2);
    measure(h, g1, l, g2);
    check("R6 cap high", h, 8);
    check("R6 low limited by period", l, 40);
    check("R10 cap gap2", g2, 2);
  endtask

  task automatic t_reset_mid();
    int guard;
    skip_mode = 1'b0;
    duty_cfg = 8'd128;
    guard = 0;
    while (hs_gate !== 1'b1 && guard < 500) begin step(); guard++; end
    rst = 1'b1;
    step();
    check("R9 mid-run reset", int'(hs_gate) + int'(ls_gate), 0);
    rst = 1'b0;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_pwm(128, 3, 20, 3, 14, 3, "half");
    t_pwm(64, 0, 10, 1, 28, 1, "quarter");
    t_pwm(255, 5, 30, 10, 0, 0, "clamp");
    t_pwm_reversal();
    t_skip_idle_and_single();
    t_skip_cont();
    t_skip_cap();
    t_reset_mid();
    repeat (5) step();
    check("R1 overlap count", overlap_cnt, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule